// File: doc/BRIEF.md
# Quadratic Extension Field Multiplier

This block multiplies two elements of the degree-two extension of a prime field, where each element is written as a real coordinate plus an imaginary coordinate times a root `i`, with `i*i` equal to the fixed non-residue 2. A caller places the modulus and the four input coordinates on the pins, pulses `start` for one cycle, and some cycles later reads the two result coordinates while `done` is high for one cycle.

The product is formed with a three-product schedule. The datapath first forms the two diagonal products. It then doubles the imaginary-by-imaginary product with a one-bit left shift followed by a conditional subtraction of the modulus, and adds the result to the real-by-real product to give the real result. Next it forms the two coordinate sums and multiplies them together. The imaginary result is that product minus the sum of the two diagonal products. All three products share one bit-serial modular multiplier, which handles one multiplier bit per clock. The additions, the subtraction and the doubling share one modular adder/subtractor. Every intermediate value and every result lies in `[0, p)`.

For the multiplication to be a field operation, the modulus must be a prime for which 2 is a quadratic non-residue, for example a prime congruent to 3 or 5 modulo 8. The arithmetic identities themselves hold for any nonzero modulus below `2**WIDTH`.

Top module: `qext_mul`

## Requirements
- R1: For reduced inputs, after `done` the real output `cRe` equals `(aRe*bRe + 2*aIm*bIm) mod p`. In particular, `(0 + 1i)*(0 + 1i)` gives `cRe = 2`, `cIm = 0`.
- R2: After `done` the imaginary output `cIm` equals `(aRe*bIm + aIm*bRe) mod p`.
- R3: Both outputs and every internal intermediate lie in `[0, p)`, including when all four inputs equal `p-1`. In that case `(p-1)(1+i)` squared gives `cRe = 3`, `cIm = 2`.
- R4: `done` is high for exactly one cycle. It is first seen high exactly `3*(WIDTH+2)+6` rising edges after the edge that accepts `start`, which is 60 edges for `WIDTH = 16`.
- R5: A `start` pulse that arrives while an operation is in progress is ignored. It changes neither the result nor the timing of `done`.
- R6: While reset (`rstN` low, active low) is asserted and after it is released, `done` is 0 and both outputs are 0 until the first operation finishes.
- R7: After `done`, `cRe` and `cIm` hold their values until the next accepted `start`, even when the input pins change.
- R8: `modP` and the four input coordinates are captured only on the edge that accepts `start`. Changing them later in the operation has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; accepted only when idle |
| modP | input | WIDTH | Prime modulus p |
| aRe | input | WIDTH | Real coordinate of the first operand |
| aIm | input | WIDTH | Imaginary coordinate of the first operand |
| bRe | input | WIDTH | Real coordinate of the second operand |
| bIm | input | WIDTH | Imaginary coordinate of the second operand |
| cRe | output | WIDTH | Real coordinate of the product |
| cIm | output | WIDTH | Imaginary coordinate of the product |
| done | output | 1 | High for one cycle when the outputs are valid |

## Verification
The assertions assume the following about the inputs at the accepting edge:
- the modulus is nonzero;
- each input coordinate is already below the modulus.

These are the conditions under which the reduced-range checks on the serial accumulator and on the shared adder can hold. The stimulus meets them in every accepted request. It uses the moduli 11, 1019 and 65521; the last lies near the 16-bit limit and is there to exercise width, not field structure. Every input coordinate is drawn below the modulus in use. Out-of-range or changing pin values appear only while the block is busy, where they must not be captured.

// File: rtl/qext_pkg.sv
package qext_pkg;

  // Which product the shared multiplier is working on (also picks the destination)
  typedef enum logic [1:0] {
    MS_NONE = 2'd0,
    MS_T0   = 2'd1,   // real * real
    MS_T1   = 2'd2,   // imag * imag
    MS_T6   = 2'd3    // (sum of a) * (sum of b)
  } mulSel_e;

  // Which adder/subtractor step runs this cycle
  typedef enum logic [2:0] {
    AS_NONE = 3'd0,
    AS_DBL  = 3'd1,   // t2 = 2*t1 mod p (shift + conditional subtract)
    AS_C0   = 3'd2,   // cRe = t0 + t2
    AS_T3   = 3'd3,   // t3 = t0 + t1
    AS_T4   = 3'd4,   // t4 = aRe + aIm
    AS_T5   = 3'd5,   // t5 = bRe + bIm
    AS_C1   = 3'd6    // cIm = t6 - t3
  } aluStep_e;

  typedef struct packed {
    logic     load;
    logic     mulGo;
    mulSel_e  mulSel;
    aluStep_e aluStep;
  } strobe_t;

endpackage

// File: rtl/qext_modmul.sv
module qext_modmul #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] modP,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prod
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] aR, bR, pR, acc, accNext;
  logic [CW-1:0]    cnt;
  logic [WIDTH:0]   dbl, dblRed, sum;

  // One interleaved step: acc = 2*acc (+a if bit) mod p, processed MSB first
  always_comb begin
    dbl     = {acc, 1'b0};
    dblRed  = (dbl >= {1'b0, pR}) ? dbl - {1'b0, pR} : dbl;
    sum     = dblRed + (bR[cnt] ? {1'b0, aR} : '0);
    accNext = (sum >= {1'b0, pR}) ? WIDTH'(sum - {1'b0, pR}) : sum[WIDTH-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aR   <= '0;
      bR   <= '0;
      pR   <= '0;
      acc  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        aR   <= opA;
        bR   <= opB;
        pR   <= modP;
        acc  <= '0;
        cnt  <= CW'(WIDTH-1);
        busy <= 1'b1;
      end else if (busy) begin
        acc <= accNext;
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign prod = acc;

  // R3: the serial accumulator never leaves [0, p)
  a_r3_acc_reduced: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (acc < pR));

  // R4: product-ready strobe lasts one cycle
  a_r4_mul_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/qext_dp.sv
module qext_dp
  import qext_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] modP,
  input  logic [WIDTH-1:0] aRe,
  input  logic [WIDTH-1:0] aIm,
  input  logic [WIDTH-1:0] bRe,
  input  logic [WIDTH-1:0] bIm,
  output logic             mulDone,
  output logic             mulBusy,
  output logic [WIDTH-1:0] cRe,
  output logic [WIDTH-1:0] cIm
);
  logic [WIDTH-1:0] pR, x0, x1, y0, y1;
  logic [WIDTH-1:0] t0, t1, t2, t3, t4, t5, t6, c0R, c1R;
  logic [WIDTH-1:0] mulA, mulB, prod;
  logic [WIDTH-1:0] opL, opR, addRed, subRed, aluOut;
  logic [WIDTH:0]   wide;
  logic             isShl, isSub;

  // Operand selection for the shared multiplier
  always_comb begin
    unique case (stb.mulSel)
      MS_T0:   begin mulA = x0; mulB = y0; end
      MS_T1:   begin mulA = x1; mulB = y1; end
      MS_T6:   begin mulA = t4; mulB = t5; end
      default: begin mulA = '0; mulB = '0; end
    endcase
  end

  qext_modmul #(.WIDTH(WIDTH)) uMul (
    .clk  (clk),
    .rstN (rstN),
    .go   (stb.mulGo),
    .opA  (mulA),
    .opB  (mulB),
    .modP (pR),
    .busy (mulBusy),
    .done (mulDone),
    .prod (prod)
  );

  // Shared modular adder / subtractor / doubler
  always_comb begin
    opL = '0;
    opR = '0;
    unique case (stb.aluStep)
      AS_DBL:  opL = t1;
      AS_C0:   begin opL = t0; opR = t2; end
      AS_T3:   begin opL = t0; opR = t1; end
      AS_T4:   begin opL = x0; opR = x1; end
      AS_T5:   begin opL = y0; opR = y1; end
      AS_C1:   begin opL = t6; opR = t3; end
      default: begin opL = '0; opR = '0; end
    endcase
    isShl  = (stb.aluStep == AS_DBL);
    isSub  = (stb.aluStep == AS_C1);
    wide   = isShl ? {opL, 1'b0} : ({1'b0, opL} + {1'b0, opR});
    addRed = (wide >= {1'b0, pR}) ? WIDTH'(wide - {1'b0, pR}) : wide[WIDTH-1:0];
    subRed = (opL >= opR) ? (opL - opR) : (opL + (pR - opR));
    aluOut = isSub ? subRed : addRed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pR <= '0; x0 <= '0; x1 <= '0; y0 <= '0; y1 <= '0;
      t0 <= '0; t1 <= '0; t2 <= '0; t3 <= '0; t4 <= '0; t5 <= '0; t6 <= '0;
      c0R <= '0; c1R <= '0;
    end else begin
      if (stb.load) begin
        pR <= modP;
        x0 <= aRe;
        x1 <= aIm;
        y0 <= bRe;
        y1 <= bIm;
      end
      if (mulDone) begin
        unique case (stb.mulSel)
          MS_T0:   t0 <= prod;
          MS_T1:   t1 <= prod;
          MS_T6:   t6 <= prod;
          default: ;
        endcase
      end
      unique case (stb.aluStep)
        AS_DBL:  t2  <= aluOut;
        AS_C0:   c0R <= aluOut;
        AS_T3:   t3  <= aluOut;
        AS_T4:   t4  <= aluOut;
        AS_T5:   t5  <= aluOut;
        AS_C1:   c1R <= aluOut;
        default: ;
      endcase
    end
  end

  assign cRe = c0R;
  assign cIm = c1R;

  // R1: accepted requests carry a nonzero modulus and reduced coordinates
  a_r1_inputs_reduced: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> (modP != '0 && aRe < modP && aIm < modP && bRe < modP && bIm < modP));

  // R3: every adder/subtractor/doubler result lands in [0, p)
  a_r3_alu_reduced: assert property (@(posedge clk) disable iff (!rstN)
    (stb.aluStep != AS_NONE) |-> (aluOut < pR));

endmodule

// File: rtl/qext_ctrl.sv
module qext_ctrl
  import qext_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    mulDone,
  input  logic    mulBusy,
  output strobe_t stb,
  output logic    done
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_M0, ST_W0, ST_M1, ST_W1, ST_DBL, ST_C0,
    ST_T3, ST_T4, ST_T5, ST_M2, ST_W2, ST_C1, ST_FIN
  } state_e;

  state_e state, nxt;

  always_comb begin
    stb = '0;
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) begin stb.load = 1'b1; nxt = ST_M0; end
      ST_M0:   begin stb.mulGo = 1'b1; stb.mulSel = MS_T0; nxt = ST_W0; end
      ST_W0:   begin stb.mulSel = MS_T0; if (mulDone) nxt = ST_M1; end
      ST_M1:   begin stb.mulGo = 1'b1; stb.mulSel = MS_T1; nxt = ST_W1; end
      ST_W1:   begin stb.mulSel = MS_T1; if (mulDone) nxt = ST_DBL; end
      ST_DBL:  begin stb.aluStep = AS_DBL; nxt = ST_C0; end
      ST_C0:   begin stb.aluStep = AS_C0;  nxt = ST_T3; end
      ST_T3:   begin stb.aluStep = AS_T3;  nxt = ST_T4; end
      ST_T4:   begin stb.aluStep = AS_T4;  nxt = ST_T5; end
      ST_T5:   begin stb.aluStep = AS_T5;  nxt = ST_M2; end
      ST_M2:   begin stb.mulGo = 1'b1; stb.mulSel = MS_T6; nxt = ST_W2; end
      ST_W2:   begin stb.mulSel = MS_T6; if (mulDone) nxt = ST_C1; end
      ST_C1:   begin stb.aluStep = AS_C1;  nxt = ST_FIN; end
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign done = (state == ST_FIN);

  // R4: completion strobe is a single-cycle pulse
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: a new product is never launched while the shared multiplier is busy
  a_r5_go_when_free: assert property (@(posedge clk) disable iff (!rstN)
    stb.mulGo |-> !mulBusy);

endmodule

// File: rtl/qext_mul.sv
module qext_mul
  import qext_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] modP,
  input  logic [WIDTH-1:0] aRe,
  input  logic [WIDTH-1:0] aIm,
  input  logic [WIDTH-1:0] bRe,
  input  logic [WIDTH-1:0] bIm,
  output logic [WIDTH-1:0] cRe,
  output logic [WIDTH-1:0] cIm,
  output logic             done
);
  strobe_t stb;
  logic    mulDone, mulBusy;

  qext_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mulDone (mulDone),
    .mulBusy (mulBusy),
    .stb     (stb),
    .done    (done)
  );

  qext_dp #(.WIDTH(WIDTH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .modP    (modP),
    .aRe     (aRe),
    .aIm     (aIm),
    .bRe     (bRe),
    .bIm     (bIm),
    .mulDone (mulDone),
    .mulBusy (mulBusy),
    .cRe     (cRe),
    .cIm     (cIm)
  );

endmodule

// File: tb/sim_qext_mul.sv
module sim_qext_mul;
  localparam int W   = 16;
  localparam int LAT = 3*(W+2)+6;
  localparam int NV  = 8;

  // p, aRe, aIm, bRe, bIm ; expected results are computed by refMul
  localparam int unsigned VEC [NV][5] = '{
    '{1019, 3, 7, 11, 13},
    '{1019, 1018, 1018, 1018, 1018},
    '{1019, 0, 1, 0, 1},
    '{1019, 500, 999, 2, 1017},
    '{11, 4, 9, 10, 6},
    '{11, 10, 0, 10, 0},
    '{65521, 65520, 12345, 40000, 65520},
    '{1019, 0, 0, 777, 123}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] modP = '0, aRe = '0, aIm = '0, bRe = '0, bIm = '0;
  logic [W-1:0] cRe, cIm;
  logic done;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  qext_mul #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .modP(modP),
    .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm),
    .cRe(cRe), .cIm(cIm), .done(done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Schoolbook reference: (ar + ai i)(br + bi i) with i*i = 2
  task automatic refMul(input longint p, ar, ai, br, bi, output longint re, im);
    re = (ar*br + 2*((ai*bi) % p)) % p;
    im = (ar*bi + ai*br) % p;
  endtask

  // Runs one request; at cycle disturbAt (0 = never) scrambles the pins and
  // optionally raises start for one cycle. Returns results and latency.
  task automatic runOp(input int p, ar, ai, br, bi, input int disturbAt,
                       input bit disturbStart, output longint re, im, output int lat);
    int cnt;
    @(negedge clk);
    modP = W'(p); aRe = W'(ar); aIm = W'(ai); bRe = W'(br); bIm = W'(bi);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 2000) begin
      @(negedge clk);
      cnt++;
      if (cnt == disturbAt) begin
        modP = W'(p - 2); aRe = W'(1); aIm = W'(2); bRe = W'(3); bIm = W'(4);
        start = disturbStart;
      end else begin
        start = 1'b0;
      end
    end
    re = cRe; im = cIm; lat = cnt;
    @(negedge clk);
    chk("R4", "done one cycle", done, 0);
  endtask

  initial begin
    #(200000*10);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint re, im, er, ei;
    int lat;

    // R6: reset state
    repeat (3) @(negedge clk);
    chk("R6", "done in reset", done, 0);
    chk("R6", "cRe in reset", cRe, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6", "done after reset", done, 0);
    chk("R6", "cIm after reset", cIm, 0);

    // Vector table: R1, R2, R3, R4
    for (int i = 0; i < NV; i++) begin
      runOp(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 0, 1'b0, re, im, lat);
      refMul(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], er, ei);
      chk("R1", $sformatf("vec%0d real", i), re, er);
      chk("R2", $sformatf("vec%0d imag", i), im, ei);
      chk("R4", $sformatf("vec%0d latency", i), lat, LAT);
    end

    // R1: i*i = 2
    runOp(1019, 0, 1, 0, 1, 0, 1'b0, re, im, lat);
    chk("R1", "i*i real", re, 2);
    chk("R2", "i*i imag", im, 0);

    // R3: all inputs p-1 -> (3, 2), fully reduced
    runOp(1019, 1018, 1018, 1018, 1018, 0, 1'b0, re, im, lat);
    chk("R3", "max operands real", re, 3);
    chk("R3", "max operands imag", im, 2);
    chk("R3", "real below p", (re < 1019), 1);

    // R5: start while busy ignored (result and timing)
    runOp(1019, 17, 23, 31, 41, 10, 1'b1, re, im, lat);
    refMul(1019, 17, 23, 31, 41, er, ei);
    chk("R5", "busy start real", re, er);
    chk("R5", "busy start imag", im, ei);
    chk("R5", "busy start latency", lat, LAT);

    // R8: pins changed mid-operation without start
    runOp(1019, 900, 5, 321, 654, 30, 1'b0, re, im, lat);
    refMul(1019, 900, 5, 321, 654, er, ei);
    chk("R8", "late pin change real", re, er);
    chk("R8", "late pin change imag", im, ei);

    // R7: outputs hold after done while pins move
    @(negedge clk);
    modP = W'(11); aRe = W'(3); aIm = W'(3); bRe = W'(3); bIm = W'(3);
    repeat (5) @(negedge clk);
    chk("R7", "hold real", cRe, er);
    chk("R7", "hold imag", cIm, ei);
    chk("R7", "no spurious done", done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule